// File: doc/BRIEF.md
# Banked Level/Edge Interrupt Controller

This block gathers interrupt sources in banks of 32 and raises one request line per bank towards a processor. Each source has two configuration bits, a polarity bit and an edge bit, which together pick one of four trigger modes:

- level, active high
- level, active low
- rising edge
- falling edge

Sources in edge mode latch a pending bit on the chosen transition, and software removes it with a write-one-to-clear register. Software can also raise any source by hand through a write-one-to-set register. Raw inputs pass through a two-flop synchronizer before any detection.

Each bank ANDs its status word with its enable word. The bank's request line is the OR of that word. The bank also reports the index of the lowest set bit, which is the source to service first. Software reaches the registers over a plain bus: writes take effect at the clock edge and reads are combinational from the byte address. Banks repeat at a fixed stride of 0x18 bytes.

Top module: `intc_banked`

## Requirements
- R1: After reset, every enable word is 0 and every polarity word is 0xFFFFFFFF. Every edge word is 0, except that bank 0's edge word is 0x0000E000 (bits 13 to 15 edge-triggered). The request lines are low while the inputs are low.
- R2: Bank b starts at byte address b*0x18. Within a bank the word offsets are 0x00 status, 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 edge. Enable, polarity and edge read back what was written. Set and clear always read 0. Writes to status are ignored. An address past the last bank, or one that falls on no listed offset, reads 0 and writes to it are ignored.
- R3: With edge bit 0, the status bit follows the input when the polarity bit is 1 and the inverted input when it is 0. A change on the input shows in status after the second rising clock edge.
- R4: With edge bit 1, a pending bit is latched on a rising input transition when the polarity bit is 1, and on a falling transition when it is 0. The pending bit is visible after the third rising clock edge that follows the input change. It stays set after the input returns to its idle level.
- R5: Writing 1 to a bit of the clear word clears that source's pending bit, and writing 0 leaves it unchanged. If a new edge is detected in the same cycle as the clear, the pending bit stays set.
- R6: Writing 1 to a bit of the set word makes that source pending in any mode. The bit then reads as 1 in status until it is cleared.
- R7: A bank's request line is high exactly when (status AND enable) is nonzero.
- R8: A bank's ID output (5 bits at bits [5b+4:5b]) is the lowest set bit index of (status AND enable).
- R9: Global source g enters on src_i[g] and belongs to bank g>>5, bit g&31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Raw interrupt sources, global index order |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr_i | input | ADDR_W | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | NUM_BANKS | One request line per bank |
| irq_id_o | output | NUM_BANKS*5 | Lowest pending enabled source index per bank |

## Verification
A corrupted pending latch stays set or stays clear, and this shows up as a wrong status read and a wrong request line within one cycle of the offending write or edge. It never heals by itself, so a later read of the same bank exposes it. A broken synchronizer or edge detector shows as a change one cycle early or late, so status is sampled exactly two cycles after a level change and three cycles after an edge. The tie between a clear and an edge in the same cycle is forced by timing the clear write into the detection cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int REG_W       = 32;
    localparam int BANK_STRIDE = 24;
    localparam int OFF_W       = 5;

    typedef enum logic [OFF_W-1:0] {
        OFF_STAT = 5'h00,
        OFF_EN   = 5'h04,
        OFF_SET  = 5'h08,
        OFF_CLR  = 5'h0C,
        OFF_POL  = 5'h10,
        OFF_EDGE = 5'h14
    } reg_off_e;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] edg;
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] sync1;
        logic [REG_W-1:0] sync2;
        logic [REG_W-1:0] prev;
    } bank_state_t;
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
    assign found_o = |vec_i;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter logic [REG_W-1:0] EDGE_RST = '0,
    parameter logic [REG_W-1:0] POL_RST  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_i,
    input  logic             wr_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [REG_W-1:0] eff_o
);
    bank_state_t      st_d, st_q;
    logic [REG_W-1:0] level_act, rise, fall, edge_hit, status;
    logic [REG_W-1:0] set_m, clr_m;
    logic             wr_set, wr_clr;

    always_comb begin
        // polarity-adjusted synchronized input
        level_act = ~(st_q.sync2 ^ st_q.pol);
        rise      = st_q.sync2 & ~st_q.prev;
        fall      = ~st_q.sync2 & st_q.prev;
        edge_hit  = st_q.edg & ((st_q.pol & rise) | (~st_q.pol & fall));
        status    = st_q.pend | (~st_q.edg & level_act);

        wr_set = wr_i && (off_i == OFF_SET);
        wr_clr = wr_i && (off_i == OFF_CLR);
        set_m  = wr_set ? wdata_i : '0;
        clr_m  = wr_clr ? wdata_i : '0;

        st_d       = st_q;
        st_d.sync1 = src_i;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        if (wr_i && (off_i == OFF_EN))   st_d.en  = wdata_i;
        if (wr_i && (off_i == OFF_POL))  st_d.pol = wdata_i;
        if (wr_i && (off_i == OFF_EDGE)) st_d.edg = wdata_i;
        // a fresh edge overrides a simultaneous clear
        st_d.pend = (st_q.pend & ~clr_m) | set_m | edge_hit;

        case (off_i)
            OFF_STAT: rdata_o = status;
            OFF_EN:   rdata_o = st_q.en;
            OFF_POL:  rdata_o = st_q.pol;
            OFF_EDGE: rdata_o = st_q.edg;
            default:  rdata_o = '0;
        endcase
        eff_o = status & st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: '0, pol: POL_RST, edg: EDGE_RST, pend: '0,
                      sync1: '0, sync2: '0, prev: '0};
        end else begin
            st_q <= st_d;
        end
    end

    p_set_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((st_q.pend & $past(wdata_i)) == $past(wdata_i)));

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set && edge_hit == '0) |=> ((st_q.pend & $past(wdata_i)) == '0));

    p_pend_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr && edge_hit == '0) |=> $stable(st_q.pend));
endmodule

// File: rtl/intc_banked.sv
module intc_banked
    import intc_pkg::*;
#(
    parameter int               NUM_BANKS      = 5,
    parameter int               ADDR_W         = 8,
    parameter logic [REG_W-1:0] BANK0_EDGE_RST = 32'h0000_E000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*REG_W-1:0]  src_i,
    input  logic                        bus_wr_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [REG_W-1:0]            bus_wdata_i,
    output logic [REG_W-1:0]            bus_rdata_o,
    output logic [NUM_BANKS-1:0]        irq_o,
    output logic [NUM_BANKS*$clog2(REG_W)-1:0] irq_id_o
);
    localparam int ID_W = $clog2(REG_W);

    logic [NUM_BANKS-1:0] hit;
    logic [REG_W-1:0]     bank_rd  [NUM_BANKS];
    logic [REG_W-1:0]     bank_eff [NUM_BANKS];
    logic [OFF_W-1:0]     bank_off [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int               BASE   = b * BANK_STRIDE;
        localparam logic [REG_W-1:0] E_RST  = (b == 0) ? BANK0_EDGE_RST : '0;
        logic [ID_W-1:0] id_b;

        assign hit[b]      = (int'(bus_addr_i) >= BASE) && (int'(bus_addr_i) < BASE + BANK_STRIDE);
        assign bank_off[b] = OFF_W'(bus_addr_i - ADDR_W'(BASE));

        intc_bank #(
            .EDGE_RST (E_RST),
            .POL_RST  ('1)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*REG_W +: REG_W]),
            .wr_i    (bus_wr_i && hit[b]),
            .off_i   (bank_off[b]),
            .wdata_i (bus_wdata_i),
            .rdata_o (bank_rd[b]),
            .eff_o   (bank_eff[b])
        );

        intc_first_set #(.W(REG_W), .IW(ID_W)) u_pick (
            .vec_i   (bank_eff[b]),
            .found_o (irq_o[b]),
            .idx_o   (id_b)
        );
        assign irq_id_o[b*ID_W +: ID_W] = id_b;

        p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_eff[b] == '0) |-> !irq_o[b]);

        p_lowest_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] |-> (bank_eff[b][id_b] &&
                          ((bank_eff[b] & ((REG_W'(1) << id_b) - REG_W'(1))) == '0)));

        p_ctl_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[b] && (bank_off[b] == OFF_SET || bank_off[b] == OFF_CLR)) |-> (bus_rdata_o == '0));
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b]) bus_rdata_o = bus_rdata_o | bank_rd[b];
        end
    end
endmodule

// File: tb/intc_banked_test.sv
`timescale 1ns/1ps
module intc_banked_test;
    localparam int NB = 5;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] src = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NB-1:0] irq;
    logic [NB*5-1:0] id;
    int vectors = 0;
    int miscompares = 0;
    logic done = 1'b0;

    intc_banked uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .irq_id_o(id)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_put(logic [7:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_get(logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_get(8'h04, v); check("R1 enable b0", v, 32'h0);
        bus_get(8'h10, v); check("R1 polarity b0", v, 32'hFFFF_FFFF);
        bus_get(8'h14, v); check("R1 edge b0", v, 32'h0000_E000);
        bus_get(8'h2C, v); check("R1 edge b1", v, 32'h0);
        check("R1 irq lines", 32'(irq), 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        bus_put(8'h34, 32'h1234_5678);
        bus_get(8'h34, v); check("R2 enable b2 readback", v, 32'h1234_5678);
        bus_put(8'h34, 32'h0);
        bus_get(8'h38, v); check("R2 set reads zero", v, 32'h0);
        bus_get(8'h3C, v); check("R2 clear reads zero", v, 32'h0);
        bus_put(8'h48, 32'hFFFF_FFFF);
        bus_get(8'h48, v); check("R2 status write ignored", v, 32'h0);
        bus_put(8'h78, 32'hFFFF_FFFF);
        bus_get(8'h78, v); check("R2 beyond map reads zero", v, 32'h0);
        bus_get(8'h05, v); check("R2 unaligned reads zero", v, 32'h0);
        check("R2 beyond-map write no irq", 32'(irq), 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        bus_put(8'h1C, 32'h0000_0010);
        src[36] = 1'b1;
        step(1);
        bus_get(8'h18, v); check("R3 level high not before 2 edges", v, 32'h0);
        step(1);
        bus_get(8'h18, v); check("R3 level high status", v, 32'h0000_0010);
        check("R7 irq bank1", 32'(irq), 32'h2);
        check("R8 id bank1", 32'(id[9:5]), 32'd4);
        src[36] = 1'b0;
        step(2);
        bus_get(8'h18, v); check("R3 level high released", v, 32'h0);
        check("R7 irq bank1 low", 32'(irq), 32'h0);
        bus_put(8'h28, 32'hFFFF_FFBF);
        bus_get(8'h18, v); check("R3 level low active", v, 32'h0000_0040);
    endtask

    task automatic t_rise;
        logic [31:0] v;
        src[13] = 1'b1;
        step(2);
        bus_get(8'h00, v); check("R4 rise not before 3 edges", v, 32'h0);
        step(1);
        bus_get(8'h00, v); check("R4 rise latched", v, 32'h0000_2000);
        src[13] = 1'b0;
        step(3);
        bus_get(8'h00, v); check("R4 rise held", v, 32'h0000_2000);
        bus_put(8'h0C, 32'hFFFF_DFFF);
        bus_get(8'h00, v); check("R5 zero bits keep pending", v, 32'h0000_2000);
        bus_put(8'h0C, 32'h0000_2000);
        bus_get(8'h00, v); check("R5 clear drops pending", v, 32'h0);
    endtask

    task automatic t_fall;
        logic [31:0] v;
        bus_put(8'h5C, 32'h1);
        bus_put(8'h58, 32'hFFFF_FFFE);
        src[96] = 1'b1;
        step(3);
        bus_get(8'h48, v); check("R4 falling ignores rise", v, 32'h0);
        src[96] = 1'b0;
        step(3);
        bus_get(8'h48, v); check("R4 falling latched", v, 32'h1);
    endtask

    task automatic t_tie;
        logic [31:0] v;
        src[14] = 1'b1; step(3);
        src[14] = 1'b0; step(3);
        bus_get(8'h00, v); check("R4 first edge b0 bit14", v, 32'h0000_4000);
        src[14] = 1'b1;
        step(2);
        bus_put(8'h0C, 32'h0000_4000);
        bus_get(8'h00, v); check("R5 edge beats clear", v, 32'h0000_4000);
        bus_put(8'h0C, 32'h0000_4000);
        bus_get(8'h00, v); check("R5 later clear", v, 32'h0);
        src[14] = 1'b0; step(3);
    endtask

    task automatic t_soft;
        logic [31:0] v;
        bus_put(8'h68, 32'h8000_0000);
        bus_get(8'h60, v); check("R6 set forces pending", v, 32'h8000_0000);
        bus_put(8'h64, 32'h8000_0000);
        check("R7 irq bank4", 32'(irq), 32'h10);
        check("R8 id bank4", 32'(id[24:20]), 32'd31);
        bus_put(8'h6C, 32'h8000_0000);
        check("R7 irq bank4 cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_prio;
        bus_put(8'h38, 32'h0010_0208);
        bus_put(8'h34, 32'h0010_0208);
        check("R8 lowest of three", 32'(id[14:10]), 32'd3);
        check("R7 only bank2", 32'(irq), 32'h4);
        bus_put(8'h3C, 32'h0000_0008);
        check("R8 next lowest", 32'(id[14:10]), 32'd9);
        bus_put(8'h34, 32'h0010_0000);
        check("R8 enable masks", 32'(id[14:10]), 32'd20);
        bus_put(8'h3C, 32'hFFFF_FFFF);
        bus_put(8'h34, 32'h0);
    endtask

    task automatic t_global;
        logic [31:0] v;
        src[70] = 1'b1;
        step(2);
        bus_get(8'h30, v); check("R9 source 70 lands in bank2 bit6", v, 32'h0000_0040);
        bus_get(8'h18, v); check("R9 bank1 untouched", v, 32'h0000_0040);
        src[70] = 1'b0;
        step(2);
    endtask

    initial begin
        #20000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_map();
        t_level();
        t_rise();
        t_fall();
        t_tie();
        t_soft();
        t_prio();
        t_global();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule